// File: doc/BRIEF.md
# CRT Controller Register File with Timing Lock and Display Geometry

This block holds the CRT controller's register file behind an index/data port pair. A write on the index port picks a register. A write on the data port then stores a byte into that register. The read port always shows the contents of the currently selected register. Indices that no register answers to read back zero, and writes to them are dropped.

The block has two additions beyond plain storage. First, a lock bit in the vertical retrace end register (0x11, bit 7) freezes the low timing registers 0x00 to 0x07. Inside that range, one bit stays open: bit 4 of the overflow register 0x07. Second, the block turns the register contents into the active display width in pixels and the active display height in lines, for the display pipeline. The height is built from the vertical display end register and two overflow bits held in register 0x07, and it is doubled when interlaced scan is selected. Both geometry outputs are registered.

Top module: `crtc_regs`

## Requirements
- R1: After reset every register and the index read zero, the read port shows 0, the width output is 8 and the height output is 1.
- R2: While bit 7 of register 0x11 is 1, data writes to registers 0x00 through 0x06 leave them unchanged. Register 0x11 itself is never locked, so clearing that bit lifts the lock for later writes.
- R3: While the lock is set, a data write to register 0x07 copies only data bit 4 into it. Bits 7:5 and 3:0 keep their old values.
- R4: The width output equals (register 0x01 + 1) * 8.
- R5: The height output equals L + 1, where L takes its bits 7:0 from register 0x12, its bit 8 from register 0x07 bit 1 and its bit 9 from register 0x07 bit 6.
- R6: When bit 0 of register 0x1A is 1, the height output is twice the value given by R5.
- R7: Indices 0x00 to 0x18 and 0x1A to 0x1D are plain byte storage, apart from the lock in R2 and R3. Every other index reads 0, and writes to it change nothing.
- R8: The width and height outputs take their new values at the same clock edge that stores the register write, so they are visible in the next cycle.
- R9: When an index write and a data write arrive in the same cycle, the data goes to the register selected before that cycle. The new index takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_we | input | 1 | Index write strobe |
| idx_wdata | input | 8 | New register index |
| dat_we | input | 1 | Data write strobe for the selected register |
| dat_wdata | input | 8 | Data byte to store |
| rd_data | output | 8 | Contents of the selected register, or zero when no register answers |
| width_px | output | 12 | Active display width in pixels |
| height_ln | output | 12 | Active display height in lines |

## Verification
The bench aims at the lock boundary. It writes register 0x07 and register 0x08 while the lock is set: a design that guards the wrong range would freeze 0x08 or let the lower bits of 0x07 change. It also sets the largest line count with interlace on, reaching 2048. A design with too narrow a sum or with the overflow bits swapped would report a wrong height there. Same-cycle index and data writes, and writes to the hole at 0x19 and to indices above 0x1D, expose designs that use the new index too early or that store into addresses no register answers to. Throughout the run, the read port and both geometry outputs are compared in every cycle against a behavioural model, which catches any output that updates one cycle late.

// File: rtl/crtc_regs.sv
module crtc_regs #(
  parameter logic [7:0] STD_LAST  = 8'h18,
  parameter logic [7:0] EXT_FIRST = 8'h1A,
  parameter logic [7:0] EXT_LAST  = 8'h1D,
  parameter logic [7:0] PROT_LAST = 8'h07
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        idx_we,
  input  logic [7:0]  idx_wdata,
  input  logic        dat_we,
  input  logic [7:0]  dat_wdata,
  output logic [7:0]  rd_data,
  output logic [11:0] width_px,
  output logic [11:0] height_ln
);
  localparam int DEPTH  = int'(EXT_LAST) + 1;
  localparam int AW     = $clog2(DEPTH);
  localparam int A_HEND = 1;
  localparam int A_OVF  = 7;
  localparam int A_LOCK = 17;
  localparam int A_VEND = 18;
  localparam int A_SCAN = 26;

  logic [7:0] regs [DEPTH];
  logic [7:0] nxt  [DEPTH];
  logic [7:0] idx_q;

  function automatic logic is_impl(input logic [7:0] a);
    return (a <= STD_LAST) || ((a >= EXT_FIRST) && (a <= EXT_LAST));
  endfunction

  wire locked = regs[A_LOCK][7];
  wire [AW-1:0] sel = idx_q[AW-1:0];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) nxt[i] = regs[i];
    if (dat_we && is_impl(idx_q)) begin
      if (locked && idx_q <= PROT_LAST) begin
        if (int'(idx_q) == A_OVF)
          nxt[A_OVF] = {regs[A_OVF][7:5], dat_wdata[4], regs[A_OVF][3:0]};
      end else begin
        nxt[sel] = dat_wdata;
      end
    end
  end

  wire [9:0]  line_end = {nxt[A_OVF][6], nxt[A_OVF][1], nxt[A_VEND]};
  wire [10:0] lines    = {1'b0, line_end} + 11'd1;
  wire [11:0] w_next   = {({1'b0, nxt[A_HEND]} + 9'd1), 3'b000};
  wire [11:0] h_next   = nxt[A_SCAN][0] ? {lines, 1'b0} : {1'b0, lines};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      width_px  <= 12'd8;
      height_ln <= 12'd1;
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= nxt[i];
      if (idx_we) idx_q <= idx_wdata;
      width_px  <= w_next;
      height_ln <= h_next;
    end
  end

  assign rd_data = is_impl(idx_q) ? regs[sel] : 8'h00;

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && !idx_we && locked && idx_q < PROT_LAST) |=> rd_data == $past(rd_data)); // R2
  AST_OVF_BIT4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && !idx_we && locked && int'(idx_q) == A_OVF) |=>
      rd_data == {$past(rd_data[7:5]), $past(dat_wdata[4]), $past(rd_data[3:0])}); // R3
  AST_WIDTH_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    width_px[2:0] == 3'b000 && width_px != 12'd0); // R4
  AST_HEIGHT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    height_ln != 12'd0); // R5
  AST_EXT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && !idx_we && idx_q >= EXT_FIRST && idx_q <= EXT_LAST) |=> rd_data == $past(dat_wdata)); // R7
  AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !is_impl(idx_q) |-> rd_data == 8'h00); // R7
endmodule

// File: tb/crtc_regs_test.sv
module crtc_regs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idx_we = 1'b0, dat_we = 1'b0;
  logic [7:0] idx_wdata = '0, dat_wdata = '0;
  logic [7:0] rd_data;
  logic [11:0] width_px, height_ln;

  int checks = 0, failures = 0;
  int mdl [256];
  int midx = 0;
  bit done = 0;

  always #5 clk = ~clk;

  crtc_regs uut (.clk(clk), .rst_n(rst_n), .idx_we(idx_we), .idx_wdata(idx_wdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata), .rd_data(rd_data),
    .width_px(width_px), .height_ln(height_ln));

  function automatic bit impl(input int a);
    return (a <= 24) || (a >= 26 && a <= 29);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mdl[i] = 0;
      midx = 0;
    end else begin
      if (dat_we && impl(midx)) begin
        if ((mdl[17] & 128) != 0 && midx <= 7) begin
          if (midx == 7) mdl[7] = (mdl[7] & 8'hEF) | (int'(dat_wdata) & 8'h10);
        end else mdl[midx] = int'(dat_wdata);
      end
      if (idx_we) midx = int'(idx_wdata);
    end
  end

  function automatic int exp_h();
    int l = mdl[18] + ((mdl[7] >> 1) & 1) * 256 + ((mdl[7] >> 6) & 1) * 512 + 1;
    return (mdl[26] & 1) ? 2 * l : l;
  endfunction

  always @(negedge clk) if (rst_n && !done) begin
    check("R7/R9 rd_data model", int'(rd_data), impl(midx) ? mdl[midx] : 0);
    check("R4/R8 width model", int'(width_px), (mdl[1] + 1) * 8);
    check("R5/R6/R8 height model", int'(height_ln), exp_h());
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); idx_we = 1; idx_wdata = 8'(a);
    @(negedge clk); idx_we = 0; dat_we = 1; dat_wdata = 8'(d);
    @(negedge clk); dat_we = 0;
  endtask

  task automatic rd(input int a, input string tag, input int exp);
    @(negedge clk); idx_we = 1; idx_wdata = 8'(a);
    @(negedge clk); idx_we = 0;
    check(tag, int'(rd_data), exp);
  endtask

  initial begin
    #200000;
    check("watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lf = 32'h1ACE5;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset rd", int'(rd_data), 0);
    check("R1 reset width", int'(width_px), 8);
    check("R1 reset height", int'(height_ln), 1);

    wr(1, 79);
    check("R4 width 640", int'(width_px), 640);
    wr(18, 8'hDF); wr(7, 8'h02);
    check("R5 height 480", int'(height_ln), 480);
    wr(26, 1);
    check("R6 interlace 960", int'(height_ln), 960);
    wr(18, 8'hFF); wr(7, 8'h42);
    check("R6 max height 2048", int'(height_ln), 2048);
    wr(26, 0);
    check("R5 max height 1024", int'(height_ln), 1024);
    wr(1, 255);
    check("R4 max width 2048", int'(width_px), 2048);

    wr(17, 8'h80);
    wr(1, 10);
    check("R2 locked width", int'(width_px), 2048);
    rd(1, "R2 locked reg1", 255);
    wr(7, 8'hBD);
    rd(7, "R3 bit4 only", 8'h52);
    wr(8, 8'h33);
    rd(8, "R2 reg8 open", 8'h33);
    wr(17, 8'h00);
    wr(1, 10);
    check("R2 unlocked width", int'(width_px), 88);

    wr(25, 8'h77);
    rd(25, "R7 hole 0x19", 0);
    wr(30, 8'h55);
    rd(30, "R7 above 0x1D", 0);
    wr(29, 8'hA5);
    rd(29, "R7 ext 0x1D", 8'hA5);

    @(negedge clk); idx_we = 1; idx_wdata = 8'd28;
    @(negedge clk); idx_wdata = 8'd27; dat_we = 1; dat_wdata = 8'h3C;
    @(negedge clk); idx_we = 0; dat_we = 0;
    check("R9 new idx active", int'(rd_data), 0);
    rd(28, "R9 data to old idx", 8'h3C);

    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      lf = (lf >> 1) ^ ((lf & 1) ? 32'hB4BCD35C : 0);
      idx_we = lf[0]; dat_we = lf[1];
      idx_wdata = lf[2] ? 8'(lf[12:8] % 32) : 8'(lf[23:16]);
      if (lf[3:2] == 2'b11) idx_wdata = 8'(lf[4] ? 17 : 7);
      dat_wdata = 8'(lf[31:24]);
    end
    @(negedge clk); idx_we = 0; dat_we = 0;
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule